// File: doc/BRIEF.md
# Tablewalk Address Assist Registers

This block holds the two table-base registers that a translation-miss handler uses to walk a two-level page table. A third register is general scratch storage. Software writes a level-1 table base and a level-2 table base through a simple register port. A miss-capture strobe latches the effective page number of the faulting access.

When software reads either base register, the block does not return the stored value as written. It merges the stored base with index bits taken from the latched page number. The value returned is the memory address of the descriptor to fetch next, so the handler needs no shift or mask instructions during the walk.

Reads are combinational on the register address. Writes take effect at the next rising clock edge. The faulting page number changes only on a strobe, so every read between two strobes refers to the same miss.

Top module: `walk_assist_regs`

## Requirements
- R1: After reset the scratch register reads 0 and the latched page number is 0, so reads of selectors 0 and 1 return the written base with an all-zero index field.
- R2: A write to selector 0 (level-1 base) keeps write-data bits 31:12 and discards bits 11:0.
- R3: A read of selector 0 returns {base[31:12], page[19:10], 2'b00}, where page is the latched page number (effective address bits 31:12), so its bits 19:10 are effective address bits 31:22.
- R4: A write to selector 1 (level-2 base) keeps write-data bits 31:12 and discards bits 11:0.
- R5: A read of selector 1 returns the level-2 base plus page[9:0] (effective address bits 21:12) times 4.
- R6: The page number is latched only at a rising edge where miss_stb is 1. Changes on miss_vpn without the strobe do not alter any read.
- R7: Selector 2 (scratch) stores and returns all 32 written bits.
- R8: Selector 3 always reads 0, and a write to it changes no other register.
- R9: A write to one selector leaves the contents of the other selectors unchanged.
- R10: reg_rdata follows reg_addr in the same cycle, and a write is visible from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register selector: 0 level-1 base, 1 level-2 base, 2 scratch, 3 unused |
| reg_we | input | 1 | Write enable for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| miss_stb | input | 1 | Capture strobe for the faulting page number |
| miss_vpn | input | 20 | Faulting effective page number (effective address bits 31:12) |

## Verification
The merge is tried with several page numbers. An all-zeros page shows the index field clears. An all-ones page shows the index reaches exactly bits 11:2 and does not spill into the base. Pages with only bit 22 or only bit 12 of the address set show which half of the page number feeds which register. A mixed page checks that the bit order is kept. Written data with nonzero low bits shows those bits are dropped. Separate tests cover the strobe gating, the unused selector and the isolation of each register from writes to the others.

// File: rtl/wa_pkg.sv
`timescale 1ns/1ps
package wa_pkg;
   typedef enum logic [1:0] {
      SEL_L1_BASE = 2'd0,
      SEL_L2_BASE = 2'd1,
      SEL_SCRATCH = 2'd2,
      SEL_UNUSED  = 2'd3
   } wa_sel_e;
endpackage

// File: rtl/wa_capture.sv
`timescale 1ns/1ps
// Holds the faulting page number between capture strobes.
module wa_capture #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (stb) q <= d;
   end

   // R6
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(q));
   // R6
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> q == $past(d));
endmodule

// File: rtl/wa_field_reg.sv
`timescale 1ns/1ps
// Register that keeps only bits W-1:DROP_LSB of the written word.
module wa_field_reg #(
   parameter int W         = 32,
   parameter int DROP_LSB  = 12,
   parameter bit HAS_RESET = 1'b0,
   localparam int SW       = W - DROP_LSB
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] d,
   output logic [W-1:0]  q
);
   logic [SW-1:0] kept;

   if (DROP_LSB < 0 || DROP_LSB >= W) begin : g_bad
      $error("wa_field_reg: DROP_LSB out of range");
   end

   if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  kept <= '0;
         else if (we) kept <= d;
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (we) kept <= d;
      end
   end

   if (DROP_LSB == 0) begin : g_full
      assign q = kept;
   end else begin : g_part
      assign q = {kept, {DROP_LSB{1'b0}}};
   end

   // R2 R4 R7
   field_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q[W-1:DROP_LSB] == $past(d));
   // R9
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/wa_entry_addr.sv
`timescale 1ns/1ps
// Merges a table base with an index scaled by the descriptor size.
module wa_entry_addr #(
   parameter int W           = 32,
   parameter int BASE_LSB    = 12,
   parameter int IDX_W       = 10,
   parameter int ENTRY_SHIFT = 2,
   localparam bit FITS       = (IDX_W + ENTRY_SHIFT) <= BASE_LSB
) (
   input  logic [W-1:0]     base,
   input  logic [IDX_W-1:0] idx,
   output logic [W-1:0]     addr
);
   logic [W-1:0] offs;
   assign offs = W'(idx) << ENTRY_SHIFT;

   if (IDX_W + ENTRY_SHIFT > W) begin : g_bad
      $error("wa_entry_addr: index does not fit the word");
   end

   if (FITS) begin : g_or
      // Base low bits are zero and the offset stays below them.
      assign addr = base | offs;
   end else begin : g_add
      assign addr = base + offs;
   end
endmodule

// File: rtl/walk_assist_regs.sv
`timescale 1ns/1ps
module walk_assist_regs #(
   parameter int DATA_W      = 32,
   parameter int BASE_LSB    = 12,
   parameter int L1_IDX_W    = 10,
   parameter int L2_IDX_W    = 10,
   parameter int ENTRY_SHIFT = 2,
   localparam int VPN_W      = DATA_W - BASE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              miss_stb,
   input  logic [VPN_W-1:0]  miss_vpn
);
   import wa_pkg::*;

   if (L1_IDX_W + L2_IDX_W != VPN_W) begin : g_bad_split
      $error("walk_assist_regs: index widths must cover the page number");
   end
   if (L1_IDX_W + ENTRY_SHIFT != BASE_LSB) begin : g_bad_l1
      $error("walk_assist_regs: level-1 index must fill the base offset");
   end

   wa_sel_e sel;
   assign sel = wa_sel_e'(reg_addr);

   logic [VPN_W-1:0]  page;
   logic [DATA_W-1:0] l1_base, l2_base, scratch;
   logic [DATA_W-1:0] l1_entry, l2_entry;

   wa_capture #(.W(VPN_W)) i_cap (
      .clk(clk), .rst_n(rst_n), .stb(miss_stb), .d(miss_vpn), .q(page));

   wa_field_reg #(.W(DATA_W), .DROP_LSB(BASE_LSB), .HAS_RESET(1'b0)) i_l1 (
      .clk(clk), .rst_n(rst_n), .we(reg_we && sel == SEL_L1_BASE),
      .d(reg_wdata[DATA_W-1:BASE_LSB]), .q(l1_base));

   wa_field_reg #(.W(DATA_W), .DROP_LSB(BASE_LSB), .HAS_RESET(1'b0)) i_l2 (
      .clk(clk), .rst_n(rst_n), .we(reg_we && sel == SEL_L2_BASE),
      .d(reg_wdata[DATA_W-1:BASE_LSB]), .q(l2_base));

   wa_field_reg #(.W(DATA_W), .DROP_LSB(0), .HAS_RESET(1'b1)) i_scr (
      .clk(clk), .rst_n(rst_n), .we(reg_we && sel == SEL_SCRATCH),
      .d(reg_wdata), .q(scratch));

   wa_entry_addr #(.W(DATA_W), .BASE_LSB(BASE_LSB), .IDX_W(L1_IDX_W),
                   .ENTRY_SHIFT(ENTRY_SHIFT)) i_l1_addr (
      .base(l1_base), .idx(page[VPN_W-1 -: L1_IDX_W]), .addr(l1_entry));

   wa_entry_addr #(.W(DATA_W), .BASE_LSB(BASE_LSB), .IDX_W(L2_IDX_W),
                   .ENTRY_SHIFT(ENTRY_SHIFT)) i_l2_addr (
      .base(l2_base), .idx(page[L2_IDX_W-1:0]), .addr(l2_entry));

   always_comb begin
      unique case (sel)
         SEL_L1_BASE: reg_rdata = l1_entry;
         SEL_L2_BASE: reg_rdata = l2_entry;
         SEL_SCRATCH: reg_rdata = scratch;
         default:     reg_rdata = '0;
      endcase
   end

   // R3
   l1_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(miss_stb) && sel == SEL_L1_BASE) |->
         reg_rdata[ENTRY_SHIFT +: L1_IDX_W] == $past(miss_vpn[VPN_W-1 -: L1_IDX_W]));
   // R8
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel == SEL_UNUSED |-> reg_rdata == '0);
endmodule

// File: tb/test_walk_assist_regs.sv
`timescale 1ns/1ps
module test_walk_assist_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        miss_stb = 1'b0;
   logic [19:0] miss_vpn = '0;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   walk_assist_regs i_walk_assist_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .miss_stb(miss_stb), .miss_vpn(miss_vpn));

   // {level-1 write, level-2 write, effective address, exp sel0, exp sel1}
   localparam int NV = 6;
   localparam logic [159:0] VEC [NV] = '{
      {32'h1234_5FFF, 32'hABCD_E123, 32'h0000_0000, 32'h1234_5000, 32'hABCD_E000},
      {32'h8000_0000, 32'h0000_1000, 32'hFFFF_FFFF, 32'h8000_0FFC, 32'h0000_1FFC},
      {32'hFFFF_F000, 32'hFFFF_FFFF, 32'h0040_0000, 32'hFFFF_F004, 32'hFFFF_F000},
      {32'h0000_1000, 32'h7654_3000, 32'h003F_F000, 32'h0000_1000, 32'h7654_3FFC},
      {32'hC0DE_0ABC, 32'h1357_9BDF, 32'hDEAD_BEEF, 32'hC0DE_0DE8, 32'h1357_9B6C},
      {32'h0000_0000, 32'h0000_0000, 32'h0080_1000, 32'h0000_0008, 32'h0000_0004}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic strobe(input logic [19:0] vpn);
      @(negedge clk);
      miss_vpn = vpn; miss_stb = 1'b1;
      @(negedge clk);
      miss_stb = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      if (!done) $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, bases written, no strobe yet
      rd(2'd2, v); check("R1 scratch after reset", v, 32'h0);
      wr(2'd0, 32'hAAAA_A000);
      wr(2'd1, 32'h5555_5000);
      rd(2'd0, v); check("R1 sel0 zero index", v, 32'hAAAA_A000);
      rd(2'd1, v); check("R1 sel1 zero index", v, 32'h5555_5000);

      // R2 R3 R4 R5 R7: vector table
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, VEC[i][159:128]);
         wr(2'd1, VEC[i][127:96]);
         strobe(VEC[i][95:76]);
         wr(2'd2, VEC[i][95:64]);
         rd(2'd0, v); check("R2 R3 sel0 entry", v, VEC[i][63:32]);
         rd(2'd1, v); check("R4 R5 sel1 entry", v, VEC[i][31:0]);
         rd(2'd2, v); check("R7 scratch", v, VEC[i][95:64]);
      end

      // R6: page number changes without strobe
      wr(2'd0, 32'h1000_0000);
      wr(2'd1, 32'h2000_0000);
      strobe(20'h00401);
      @(negedge clk); miss_vpn = 20'hFFFFF;
      repeat (3) @(negedge clk);
      rd(2'd0, v); check("R6 sel0 held", v, 32'h1000_0004);
      rd(2'd1, v); check("R6 sel1 held", v, 32'h2000_0004);

      // R8: unused selector
      wr(2'd2, 32'h0BAD_F00D);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, v); check("R8 sel3 reads zero", v, 32'h0);
      rd(2'd0, v); check("R8 sel0 untouched", v, 32'h1000_0004);
      rd(2'd1, v); check("R8 sel1 untouched", v, 32'h2000_0004);
      rd(2'd2, v); check("R8 scratch untouched", v, 32'h0BAD_F00D);

      // R9: write to scratch and level-2 leave level-1 alone
      wr(2'd2, 32'h1111_2222);
      wr(2'd1, 32'h3000_0FFF);
      rd(2'd0, v); check("R9 sel0 isolated", v, 32'h1000_0004);
      rd(2'd2, v); check("R9 scratch isolated", v, 32'h1111_2222);

      // R10: write visible from the cycle after the edge
      @(negedge clk);
      reg_addr = 2'd2; reg_wdata = 32'hCAFE_0001; reg_we = 1'b1;
      #1 check("R10 before edge", reg_rdata, 32'h1111_2222);
      @(negedge clk);
      reg_we = 1'b0;
      #1 check("R10 after edge", reg_rdata, 32'hCAFE_0001);
      reg_addr = 2'd1;
      #1 check("R10 same-cycle select", reg_rdata, 32'h3000_0004);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule